// File: doc/BRIEF.md
# Periodic Interval Timer

A memory-mapped timer that divides the system clock by a fixed prescale factor and advances an in-period counter on every prescaled tick. When the counter reaches the programmed period limit it returns to zero. Each return bumps a saturating tally of completed periods and raises a status flag. Software combines the tally and the in-period count into a monotonic timestamp. It can also take a periodic level interrupt by enabling it.

Two value registers return the same counter snapshot. Reading the acknowledging one also clears the tally and the status flag, which drops the interrupt. Reading the other one changes nothing, so it is the one to use for timestamps. Clearing the enable bit does not freeze the counter at once. The current period runs to its end, and the counter then holds at zero. Software polls for a zero count to know the timer has stopped.

Top module: `pit_timer`

## Requirements
- R1: The in-period counter advances by one once every 16 clock cycles (PRESCALE) while the timer runs. The prescaler restarts from zero whenever the timer is idle.
- R2: The period field holds the desired period minus one. When a tick finds the count at or above the field, the count returns to 0, so each period lasts field+1 ticks.
- R3: The timer enable and the interrupt enable are separate bits. The count and tally advance with the interrupt enable clear, and `irq` then stays low.
- R4: Both value registers return the in-period count in bits [19:0] and the elapsed-period tally in bits [31:20].
- R5: A read of the acknowledging value register (offset 0x8) returns the snapshot taken before the read. It then clears the tally and the status flag, so `irq` falls the cycle after.
- R6: A read of the plain value register (offset 0xC) returns the same layout and has no side effect on the tally, the status flag or `irq`.
- R7: Status bit 0 (offset 0x4) sets on every wrap. `irq` is high exactly when that flag and the interrupt enable are both set.
- R8: After the enable is cleared, counting continues to the end of the current period and then holds at 0.
- R9: The mode register is at offset 0x0. It holds the period in [19:0], the enable in bit 24 and the interrupt enable in bit 25, and it reads back with the same layout. Read data appears on `rdata` one cycle after `rd_en`.
- R10: The tally saturates at 4095 instead of wrapping.
- R11: When a wrap and an acknowledging read fall in the same cycle, the read returns the old snapshot. The tally then becomes 1 and the status flag stays set.
- R12: After reset, every register reads zero, the timer is disabled and `irq` is low.
- R13: Writes to offsets 0x4, 0x8 and 0xC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a prescale of 16, a 20-bit count and a 12-bit tally. It programs periods of 0 to 7 so that wraps, acknowledges and disables collide often. A period of zero wraps on every tick, which brings the 4095 saturation point within about 66,000 cycles and places a wrap on a known cycle so a directed acknowledging read can meet it.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned OFS_MODE  = 4'h0;
  localparam int unsigned OFS_STAT  = 4'h4;
  localparam int unsigned OFS_ACK   = 4'h8;
  localparam int unsigned OFS_PEEK  = 4'hC;
  localparam int unsigned EN_BIT    = 24;
  localparam int unsigned IE_BIT    = 25;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned PRESCALE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick = run;
    end else begin : g_div
      localparam int unsigned DIV_W = $clog2(PRESCALE);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(PRESCALE - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst || !run)
          div_q <= '0;
        else if (div_q == LAST)
          div_q <= '0;
        else
          div_q <= div_q + 1'b1;
      end

      assign tick = run && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pit_period_counter.sv
module pit_period_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (wrap)
      cnt <= '0;
    else if (tick)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pit_tally.sv
module pit_tally #(
  parameter int unsigned TALLY_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrap,
  input  logic               ack,
  output logic [TALLY_W-1:0] tally,
  output logic               flag
);
  localparam logic [TALLY_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tally <= '0;
      flag  <= 1'b0;
    end else if (wrap && ack) begin
      tally <= TALLY_W'(1);
      flag  <= 1'b1;
    end else if (wrap) begin
      tally <= (tally == TOP) ? TOP : tally + 1'b1;
      flag  <= 1'b1;
    end else if (ack) begin
      tally <= '0;
      flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned CNT_W    = 20,
  parameter int unsigned TALLY_W  = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  output logic        irq
);
  import pit_pkg::*;

  localparam int unsigned DATA_W = CNT_W + TALLY_W;

  logic [CNT_W-1:0]   period_q;
  logic               en_q;
  logic               ie_q;
  logic [CNT_W-1:0]   cnt;
  logic [TALLY_W-1:0] tally;
  logic               flag;
  logic               tick;
  logic               wrap;
  logic               run;
  logic               ack;
  logic               wr_mode;
  logic [DATA_W-1:0]  snap;
  logic [31:0]        mode_view;
  logic [31:0]        rd_mux;

  assign run     = en_q || (cnt != '0);
  assign ack     = rd_en && (addr == 4'(OFS_ACK));
  assign wr_mode = wr_en && (addr == 4'(OFS_MODE));

  pit_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  pit_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .limit(period_q),
    .cnt  (cnt),
    .wrap (wrap)
  );

  pit_tally #(.TALLY_W(TALLY_W)) u_tally (
    .clk  (clk),
    .rst  (rst),
    .wrap (wrap),
    .ack  (ack),
    .tally(tally),
    .flag (flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
    end else if (wr_mode) begin
      period_q <= wdata[CNT_W-1:0];
      en_q     <= wdata[EN_BIT];
      ie_q     <= wdata[IE_BIT];
    end
  end

  assign snap = {tally, cnt};

  always_comb begin
    mode_view            = '0;
    mode_view[CNT_W-1:0] = period_q;
    mode_view[EN_BIT]    = en_q;
    mode_view[IE_BIT]    = ie_q;
  end

  always_comb begin
    case (addr)
      4'(OFS_MODE): rd_mux = mode_view;
      4'(OFS_STAT): rd_mux = {31'd0, flag};
      4'(OFS_ACK),
      4'(OFS_PEEK): rd_mux = 32'(snap);
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  assign irq = flag && ie_q;
endmodule

// File: rtl/pit_timer_sva.sv
module pit_timer_sva #(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned TALLY_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               wrap,
  input logic               ack,
  input logic               peek,
  input logic               tick,
  input logic [CNT_W-1:0]   cnt,
  input logic               en,
  input logic               ie,
  input logic               flag,
  input logic [TALLY_W-1:0] tally,
  input logic               irq
);
  localparam logic [TALLY_W-1:0] TOP = '1;

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && ie));

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !wrap) |=> (tally == '0 && !flag && !irq));

  a_r11_ack_meets_wrap: assert property (@(posedge clk) disable iff (rst)
    (ack && wrap) |=> (tally == TALLY_W'(1) && flag));

  a_r10_saturate: assert property (@(posedge clk) disable iff (rst)
    (tally == TOP && !ack) |=> (tally == TOP));

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (!en && cnt == '0) |=> (cnt == '0));

  a_r6_peek_quiet: assert property (@(posedge clk) disable iff (rst)
    (peek && !wrap) |=> ($stable(tally) && $stable(flag)));

  a_r1_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> $stable(cnt));
endmodule

bind pit_timer pit_timer_sva #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_sva (
  .clk  (clk),
  .rst  (rst),
  .wrap (wrap),
  .ack  (ack),
  .peek (rd_en && addr == 4'hC),
  .tick (tick),
  .cnt  (cnt),
  .en   (en_q),
  .ie   (ie_q),
  .flag (flag),
  .tally(tally),
  .irq  (irq)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  pit_timer dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
                 .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  int unsigned m_div, m_cnt, m_tally, m_period;
  bit m_en, m_ie, m_stat;
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return {6'd0, m_ie, m_en, 4'd0, 20'(m_period)};
      4'h4: return {31'd0, m_stat};
      4'h8, 4'hC: return {12'(m_tally), 20'(m_cnt)};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit run, tk, wr, ak;
    if (rst) begin
      m_div = 0; m_cnt = 0; m_tally = 0; m_period = 0;
      m_en = 0; m_ie = 0; m_stat = 0; m_rdata = '0;
    end else begin
      ak = rd_en && addr == 4'h8;
      if (rd_en) m_rdata = model_read(addr);
      run = m_en || m_cnt != 0;
      tk = 0;
      if (!run) m_div = 0;
      else if (m_div == PS-1) begin m_div = 0; tk = 1; end
      else m_div++;
      wr = tk && m_cnt >= m_period;
      if (wr) m_cnt = 0; else if (tk) m_cnt++;
      if (wr && ak) begin m_tally = 1; m_stat = 1; end
      else if (wr) begin if (m_tally < 4095) m_tally++; m_stat = 1; end
      else if (ak) begin m_tally = 0; m_stat = 0; end
      if (wr_en && addr == 4'h0) begin
        m_period = wdata[19:0]; m_en = wdata[24]; m_ie = wdata[25];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_model(input logic [3:0] a, input string req);
    logic [31:0] d;
    rd_reg(a, d);
    check(d === m_rdata, req, d, m_rdata);
    check(irq === (m_stat && m_ie), "R7 irq", 32'(irq), 32'(m_stat && m_ie));
  endtask

  function automatic logic [31:0] mode_word(input int p, input bit en, input bit ie);
    return {6'd0, ie, en, 4'd0, 20'(p)};
  endfunction

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [31:0] d, d2;
    void'($urandom(32'd12345));
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R12: reset state
    for (int a = 0; a < 16; a += 4) begin
      rd_reg(4'(a), d);
      check(d == 0, "R12 reset read", d, 0);
    end
    check(irq == 0, "R12 irq after reset", 32'(irq), 0);

    // R9 mode readback, R1 prescaled advance
    wr_reg(4'h0, mode_word(1000, 1, 0));
    rd_reg(4'h0, d);
    check(d == mode_word(1000, 1, 0), "R9 mode readback", d, mode_word(1000, 1, 0));
    idle(16 * 5 + 3);
    rd_reg(4'hC, d);
    check(d[19:0] >= 5 && d[19:0] <= 6, "R1 count after ~5 ticks", d, 5);
    rd_model(4'hC, "R1 model");

    // R13: writes to other offsets ignored
    wr_reg(4'h4, 32'hFFFF_FFFF);
    wr_reg(4'h8, 32'hFFFF_FFFF);
    wr_reg(4'hC, 32'hFFFF_FFFF);
    rd_reg(4'h0, d);
    check(d == mode_word(1000, 1, 0), "R13 mode unchanged", d, mode_word(1000, 1, 0));
    rd_reg(4'h4, d);
    check(d == 0, "R13 status unchanged", d, 0);

    // R2, R3, R4: period 3 (4 ticks), interrupts off
    wr_reg(4'h0, mode_word(3, 1, 0));
    idle(16 * 4 * 3 + 20);
    rd_reg(4'hC, d);
    check(d[31:20] >= 3 && d[19:0] <= 3, "R2 R4 tally/count layout", d, 32'h0030_0000);
    check(irq == 0, "R3 irq low with ie clear", 32'(irq), 0);
    rd_model(4'h4, "R7 status set");

    // R6: plain read has no side effect
    rd_reg(4'hC, d);
    rd_reg(4'hC, d2);
    check(d2[31:20] >= d[31:20], "R6 tally kept", d2, d);
    rd_model(4'hC, "R6 model");

    // R7 + R5: enable interrupt then acknowledge
    wr_reg(4'h0, mode_word(2000, 1, 1));
    check(irq == 1, "R7 irq when flag and ie", 32'(irq), 1);
    rd_model(4'h8, "R5 ack snapshot");
    rd_reg(4'hC, d);
    check(d[31:20] == 0, "R5 tally cleared", d, 0);
    check(irq == 0, "R5 irq dropped", 32'(irq), 0);
    rd_reg(4'h4, d);
    check(d == 0, "R5 status cleared", d, 0);

    // R11: acknowledge on the wrap cycle
    wr_reg(4'h0, mode_word(0, 1, 1));
    idle(40);
    while (!(m_en && m_div == PS-1)) @(negedge clk);
    rd_model(4'h8, "R11 old snapshot");
    rd_reg(4'hC, d);
    check(d[31:20] == 1, "R11 tally is one", d, 32'h0010_0000);
    rd_reg(4'h4, d);
    check(d == 1, "R11 status kept", d, 1);

    // R8: disable lets the period finish and hold at zero
    wr_reg(4'h0, mode_word(5, 1, 0));
    idle(16 * 2 + 5);
    wr_reg(4'h0, mode_word(5, 0, 0));
    rd_reg(4'hC, d);
    check(d[19:0] != 0, "R8 still counting after disable", d, 1);
    idle(16 * 8);
    rd_reg(4'hC, d);
    check(d[19:0] == 0, "R8 stopped at zero", d, 0);
    idle(16 * 4);
    rd_reg(4'hC, d2);
    check(d2 == d, "R8 holds", d2, d);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2)
        wr_reg(4'h0, mode_word($urandom_range(0, 7), $urandom_range(0, 3) != 0,
                               $urandom_range(0, 1) != 0));
      else if (op < 6)
        rd_model(4'($urandom_range(0, 3) * 4), "R2 R4 R5 R6 R11 random");
      else if (op < 7)
        wr_reg(4'($urandom_range(1, 3) * 4), $urandom);
      else
        idle($urandom_range(1, 20));
    end

    // R10: saturation
    wr_reg(4'h0, mode_word(0, 1, 0));
    rd_reg(4'h8, d);
    idle(16 * 4100);
    rd_reg(4'hC, d);
    check(d[31:20] == 12'hFFF, "R10 tally saturates", d, 32'hFFF0_0000);
    idle(64);
    rd_model(4'hC, "R10 model");

    done = 1;
    report();
  end
endmodule